// File: doc/BRIEF.md
# Serial-Bus Quad Wiper Register Controller

This block is a two-wire serial bus slave (I2C protocol, slave side only) that holds four byte-wide wiper settings and presents them as parallel outputs. Its usual consumer is a set of tap selectors in a mixed-signal macro. The raw SCL and SDA lines are sampled by a faster system clock. Each line passes through a synchronizer and a stability filter. Edge logic then derives START, STOP and the SCL edges, and a byte-level state machine acts on those events.

A host selects the block with an identification byte. The upper five bits of that byte are the fixed pattern 01010, the next two bits must match two strap inputs, and the last bit selects read or write. A register address byte follows. A write then carries exactly one data byte. A read needs a repeated START and a second identification byte with the read bit set. The slave then streams register contents from a pointer that steps upward and wraps from the last register back to register 0, for as long as the host acknowledges. SDA is open drain: the block only ever pulls the line low, through an output enable.

Top module: `quad_wiper_i2c`

## Requirements
- R1: After reset every wiper register holds 80h and the SDA output enable is inactive.
- R2: A write (START, identification byte with bit 0 = 0, address byte, data byte) is acknowledged by the slave pulling SDA low in the ninth clock of each of the three bytes. The addressed wiper output takes the data value on the SCL falling edge that ends the eighth data bit, before the STOP.
- R3: An identification byte is accepted only when bits 7:3 equal 01010 and bits 2:1 equal strap_i[1:0]. Bit 0 is 1 for read and 0 for write. A mismatch gets no acknowledge, and the block ignores the bus until the next START.
- R4: Address byte values 00h to 03h select wiper register 0 to 3. Any larger value gets no acknowledge, and the following data byte is neither acknowledged nor written.
- R5: In a write, every data byte after the first gets no acknowledge and leaves all wiper registers unchanged.
- R6: A read (START, write identification byte, address byte, repeated START, identification byte with bit 0 = 1) is acknowledged on all three bytes. The slave then sends the addressed register, most significant bit first.
- R7: During a read the pointer advances after each byte sent and wraps from 3 to 0. Further bytes follow while the host drives SDA low in each ninth clock.
- R8: A host NACK ends the read. SDA stays released, so any further clocked bits read as 1 until the next START.
- R9: Bytes clocked on the bus before any START get no acknowledge and change no register.
- R10: A pulse on SDA or SCL shorter than FILT_LEN system clocks is rejected, so a short low glitch on SDA while SCL is high does not act as a START.
- R11: The SDA output enable is asserted only to send a 0 data bit or an acknowledge. It changes only after a detected SCL falling edge, or when a START or STOP releases it, and never in the system clock right after the host lowers SCL.
- R12: A STOP, or a START, releases SDA and returns the block to its idle state. A following transfer then works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the pad |
| sda_i | input | 1 | Serial data line as seen on the pad |
| strap_i | input | 2 | Strapped address bits compared with identification bits 2:1 |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| wiper_o | output | NUM_REGS*REG_W | Wiper registers, register 0 in the least significant byte |

## Verification
The assertions assume the host changes SDA only while SCL is low, except for START and STOP, and holds each SCL phase for well over the synchronizer and filter latency. Under that assumption the slave's output enable can move only after a filtered falling edge, or when a START or STOP releases it. The bench drives every line change a quarter bit period after the previous SCL transition, with twelve system clocks per quarter. Each transition is therefore seen after the filter has settled. The only deliberate violations are SDA glitches shorter than the filter length, which the filter is expected to absorb.

// File: rtl/qw_pkg.sv
package qw_pkg;

  localparam logic [4:0] QW_ID_PREFIX = 5'b01010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } bus_st_t;

  typedef enum logic [1:0] {
    K_ID,
    K_ADDR,
    K_DATA,
    K_EXTRA
  } rx_kind_t;

  // Identification check: fixed prefix plus strapped bits; bit 0 is direction.
  function automatic logic id_match(input logic [7:0] b, input logic [1:0] strap);
    return (b[7:3] == QW_ID_PREFIX) && (b[2:1] == strap);
  endfunction

  function automatic logic addr_ok(input logic [7:0] a, input int unsigned n);
    return 32'(a) < n;
  endfunction

  // Pointer step with wrap to zero after the last register.
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/qw_line_filter.sv
module qw_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_LEN-1:0]    hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '1;
      hist_q  <= '1;
      clean_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      if (&hist_q)       clean_o <= 1'b1;
      else if (~|hist_q) clean_o <= 1'b0;
    end
  end

endmodule

// File: rtl/qw_bus_events.sv
module qw_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/qw_reg_bank.sv
module qw_reg_bank #(
  parameter int          NUM_REGS  = 4,
  parameter int          REG_W     = 8,
  parameter logic [7:0]  RESET_VAL = 8'h80
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [IDX_W-1:0]          wr_idx,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [REG_W-1:0]          rd_data,
  output logic [NUM_REGS*REG_W-1:0] flat_o
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [REG_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             regs[g] <= REG_W'(RESET_VAL);
      else if (wr_en && wr_idx == IDX_W'(g))  regs[g] <= wr_data;
    end
    assign flat_o[g*REG_W +: REG_W] = regs[g];
  end

  assign rd_data = regs[rd_idx];

endmodule

// File: rtl/quad_wiper_i2c.sv
module quad_wiper_i2c #(
  parameter int          NUM_REGS    = 4,
  parameter int          REG_W       = 8,
  parameter logic [7:0]  RESET_VAL   = 8'h80,
  parameter int          SYNC_STAGES = 2,
  parameter int          FILT_LEN    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [1:0]                strap_i,
  output logic                      sda_oe_o,
  output logic [NUM_REGS*REG_W-1:0] wiper_o
);
  import qw_pkg::*;

  localparam int PTR_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  // Filtered lines: index 1 is SCL, index 0 is SDA.
  logic [1:0] raw_lines, clean_lines;
  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    qw_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_lines[g]), .clean_o(clean_lines[g])
    );
  end

  logic scl_c, sda_c;
  assign scl_c = clean_lines[1];
  assign sda_c = clean_lines[0];

  // Named bus events, also watched by the checker.
  logic scl_rise, scl_fall, start_evt, stop_evt;

  qw_bus_events u_evt (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_c), .sda_i(sda_c),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  bus_st_t          st;
  rx_kind_t         kind;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       txsh;
  logic [PTR_W-1:0] ptr;
  logic             rd_mode;
  logic             m_ack;
  logic             drive_low;
  logic [REG_W-1:0] rd_data;

  logic byte_done, wr_en;
  assign byte_done = (st == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign wr_en     = byte_done && (kind == K_DATA);

  qw_reg_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .RESET_VAL(RESET_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(ptr), .wr_data(shreg[REG_W-1:0]),
    .rd_idx(ptr), .rd_data(rd_data), .flat_o(wiper_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      kind      <= K_ID;
      bitcnt    <= '0;
      shreg     <= '0;
      txsh      <= '0;
      ptr       <= '0;
      rd_mode   <= 1'b0;
      m_ack     <= 1'b0;
      drive_low <= 1'b0;
    end else if (stop_evt) begin
      st        <= ST_IDLE;
      drive_low <= 1'b0;
    end else if (start_evt) begin
      st        <= ST_RX;
      kind      <= K_ID;
      bitcnt    <= '0;
      drive_low <= 1'b0;
    end else begin
      unique case (st)
        ST_RX: begin
          if (scl_rise && bitcnt < 4'd8) begin
            shreg  <= {shreg[6:0], sda_c};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_done) begin
            bitcnt <= '0;
            unique case (kind)
              K_ID: begin
                if (id_match(shreg, strap_i)) begin
                  drive_low <= 1'b1;
                  st        <= ST_ACK;
                  rd_mode   <= shreg[0];
                  kind      <= K_ADDR;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_ADDR: begin
                if (addr_ok(shreg, NUM_REGS)) begin
                  ptr       <= shreg[PTR_W-1:0];
                  drive_low <= 1'b1;
                  st        <= ST_ACK;
                  kind      <= K_DATA;
                end else begin
                  st <= ST_IDLE;
                end
              end
              K_DATA: begin
                drive_low <= 1'b1;
                st        <= ST_ACK;
                kind      <= K_EXTRA;
              end
              K_EXTRA: ;
              default: ;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (rd_mode) begin
              st        <= ST_TX;
              txsh      <= 8'(rd_data);
              drive_low <= ~rd_data[REG_W-1];
              bitcnt    <= '0;
            end else begin
              drive_low <= 1'b0;
              st        <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitcnt == 4'd7) begin
              drive_low <= 1'b0;
              st        <= ST_TXACK;
              ptr       <= PTR_W'(ptr_step(32'(ptr), NUM_REGS));
            end else begin
              bitcnt    <= bitcnt + 4'd1;
              txsh      <= {txsh[6:0], 1'b0};
              drive_low <= ~txsh[6];
            end
          end
        end
        ST_TXACK: begin
          if (scl_rise) begin
            m_ack <= ~sda_c;
          end else if (scl_fall) begin
            if (m_ack) begin
              st        <= ST_TX;
              txsh      <= 8'(rd_data);
              drive_low <= ~rd_data[REG_W-1];
              bitcnt    <= '0;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = drive_low;

endmodule

// File: rtl/qw_checker.sv
module qw_checker #(
  parameter int          NUM_REGS  = 4,
  parameter int          REG_W     = 8,
  parameter logic [7:0]  RESET_VAL = 8'h80
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      sda_oe,
  input logic                      scl_lvl,
  input logic                      scl_fall,
  input logic                      start_evt,
  input logic                      stop_evt,
  input logic                      wr_en,
  input logic [NUM_REGS*REG_W-1:0] wiper
);

  p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wiper == {NUM_REGS{REG_W'(RESET_VAL)}}));

  p_wiper_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_en) |-> $stable(wiper));

  p_write_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !scl_lvl);

  p_oe_rise_after_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> $past(scl_fall));

  p_oe_steady_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_lvl && $past(scl_lvl) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));

  p_release_after_stop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stop_evt) |-> !sda_oe);

  p_release_after_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_evt) |-> !sda_oe);

endmodule

bind quad_wiper_i2c qw_checker #(
  .NUM_REGS(NUM_REGS), .REG_W(REG_W), .RESET_VAL(RESET_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .scl_lvl(scl_c),
  .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
  .wr_en(wr_en), .wiper(wiper_o)
);

// File: tb/quad_wiper_i2c_bench.sv
module quad_wiper_i2c_bench;

  localparam int Q = 12;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [7:0] ID_W = {5'b01010, STRAP, 1'b0};
  localparam logic [7:0] ID_R = {5'b01010, STRAP, 1'b1};
  localparam int NV = 6;
  // {address, data} pairs written and read back
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 8'h3C}, {2'd3, 8'hFF}, {2'd1, 8'h00},
    {2'd2, 8'hA5}, {2'd0, 8'h01}, {2'd3, 8'h6E}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic [31:0] wiper;
  logic sda_line;
  logic [7:0] model [4];
  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  quad_wiper_i2c u_quad_wiper_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe), .wiper_o(wiper)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(2*Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = ~sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    logic oe_hi;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b[i] = sda_line;
      oe_hi = sda_oe;
      tick(Q);
      scl_m = 1'b0; tick(1);
      chk(sda_oe == oe_hi, "R11 oe moved right after SCL fall", 32'(sda_oe), 32'(oe_hi));
      tick(Q - 1);
    end
    sda_m = ~give_ack; tick(Q);
    scl_m = 1'b1; tick(2*Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_frame(input logic [7:0] id, input logic [7:0] ab, input logic [7:0] db,
                          output bit a1, output bit a2, output bit a3);
    bus_start();
    send_byte(id, a1);
    send_byte(ab, a2);
    send_byte(db, a3);
  endtask

  task automatic read_check(input int addr, input int len, input string tag);
    bit a1, a2, a3;
    logic [7:0] got;
    bus_start();
    send_byte(ID_W, a1);
    send_byte(8'(addr), a2);
    bus_start();
    send_byte(ID_R, a3);
    chk(a1 && a2 && a3, {tag, " read header ACKs"}, {29'd0, a1, a2, a3}, 32'h7);
    for (int k = 0; k < len; k++) begin
      recv_byte(got, k < len - 1);
      chk(got == model[(addr + k) % 4], {tag, " read data"}, 32'(got), 32'(model[(addr + k) % 4]));
    end
    bus_stop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    bit a1, a2, a3;
    logic [7:0] got;
    for (int i = 0; i < 4; i++) model[i] = 8'h80;
    tick(5);
    chk(wiper == 32'h80808080, "R1 reset wipers", wiper, 32'h80808080);
    chk(sda_oe == 1'b0, "R1 reset oe", 32'(sda_oe), 32'h0);
    rst_n = 1'b1;
    tick(4*Q);

    // Vector table: write then read back each entry (R2, R4, R6)
    for (int v = 0; v < NV; v++) begin
      int ad;
      logic [7:0] dv;
      ad = int'(VEC[v][9:8]);
      dv = VEC[v][7:0];
      wr_frame(ID_W, 8'(ad), dv, a1, a2, a3);
      chk(a1 && a2 && a3, "R2 write ACKs", {29'd0, a1, a2, a3}, 32'h7);
      model[ad] = dv;
      chk(wiper[ad*8 +: 8] == dv, "R2 R4 wiper updated before STOP", 32'(wiper[ad*8 +: 8]), 32'(dv));
      bus_stop();
      chk(sda_oe == 1'b0, "R12 released after STOP", 32'(sda_oe), 32'h0);
      read_check(ad, 1, "R6");
    end

    // R3: wrong strap bits, then wrong prefix
    wr_frame({5'b01010, 2'b01, 1'b0}, 8'h01, 8'h11, a1, a2, a3);
    bus_stop();
    chk(!a1 && !a2 && !a3, "R3 strap mismatch no ACK", {29'd0, a1, a2, a3}, 32'h0);
    wr_frame({5'b11010, STRAP, 1'b0}, 8'h01, 8'h11, a1, a2, a3);
    bus_stop();
    chk(!a1 && !a2 && !a3, "R3 prefix mismatch no ACK", {29'd0, a1, a2, a3}, 32'h0);
    chk(wiper == {model[3], model[2], model[1], model[0]}, "R3 wipers unchanged",
        wiper, {model[3], model[2], model[1], model[0]});

    // R4: out-of-range address
    wr_frame(ID_W, 8'h04, 8'h22, a1, a2, a3);
    bus_stop();
    chk(a1 && !a2 && !a3, "R4 address 04h no ACK", {29'd0, a1, a2, a3}, 32'h4);
    chk(wiper == {model[3], model[2], model[1], model[0]}, "R4 wipers unchanged",
        wiper, {model[3], model[2], model[1], model[0]});

    // R5: second data byte refused
    wr_frame(ID_W, 8'h01, 8'h5A, a1, a2, a3);
    send_byte(8'hC3, a1);
    bus_stop();
    model[1] = 8'h5A;
    chk(!a1, "R5 extra byte no ACK", 32'(a1), 32'h0);
    chk(wiper[15:8] == 8'h5A, "R5 extra byte discarded", 32'(wiper[15:8]), 32'h5A);

    // R7: streaming read with wrap
    read_check(2, 6, "R7");

    // R8: NACK ends read, further bits read as ones
    bus_start();
    send_byte(ID_W, a1);
    send_byte(8'h03, a2);
    bus_start();
    send_byte(ID_R, a3);
    recv_byte(got, 1'b0);
    chk(got == model[3], "R8 single byte", 32'(got), 32'(model[3]));
    recv_byte(got, 1'b0);
    chk(got == 8'hFF, "R8 released after NACK", 32'(got), 32'hFF);
    bus_stop();

    // R9: bytes without START
    scl_m = 1'b0; tick(Q);
    send_byte(ID_W, a1);
    send_byte(8'h00, a2);
    send_byte(8'h77, a3);
    bus_stop();
    chk(!a1 && !a2 && !a3, "R9 no START no ACK", {29'd0, a1, a2, a3}, 32'h0);
    chk(wiper[7:0] == model[0], "R9 register untouched", 32'(wiper[7:0]), 32'(model[0]));

    // R10: short SDA glitch while SCL high is not a START
    sda_m = 1'b0; tick(2);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b0; tick(Q);
    send_byte(ID_W, a1);
    chk(!a1, "R10 glitch not a START", 32'(a1), 32'h0);
    send_byte(8'h00, a2);
    send_byte(8'h99, a3);
    bus_stop();
    chk(wiper[7:0] == model[0], "R10 register untouched", 32'(wiper[7:0]), 32'(model[0]));

    // R12: normal transfer after all of the above
    wr_frame(ID_W, 8'h02, 8'h3E, a1, a2, a3);
    bus_stop();
    model[2] = 8'h3E;
    chk(a1 && a2 && a3 && wiper[23:16] == 8'h3E, "R12 recovery write",
        {wiper[23:16], 21'd0, a1, a2, a3}, {8'h3E, 24'h7});
    chk(sda_oe == 1'b0, "R12 idle released", 32'(sda_oe), 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule